// File: doc/BRIEF.md
# GF(2^128) Polynomial Residue Unit

This unit takes the carryless product of two 128-bit binary polynomials and returns its residue modulo the field polynomial x^128 + x^7 + x^2 + x + 1. The product arrives as a 256-bit word. Its top bit is always clear, so only bits [254:0] matter. Each product comes with a valid strobe, and the 128-bit residue leaves on a registered output one clock later.

The reduction needs no divider. The bits at and above position 128 are multiplied carrylessly by the sparse tail 0x87, using four fixed shifted copies combined with XOR. That product is XORed onto the low 128 bits. The first pass can leave at most six bits above bit 127. A second, much narrower pass folds those bits back, and its result always fits in 128 bits.

A mode input, `short_op`, is for callers who know that one operand is at most 122 bits wide. In that mode the block returns the result of the first pass alone. It flags an error if that pass left any overflow bits.

Top module: `gf128_reduce`

## Requirements
- R1: With `short_op` low, `residue` equals the input product reduced modulo x^128+x^7+x^2+x+1 over GF(2). This holds for every value of bits [254:0].
- R2: Input bit 255 never affects `residue` or `short_err`.
- R3: An input whose bits [254:128] are all zero is returned unchanged in `residue`, in either mode.
- R4: `valid_out` is high in exactly the cycles that follow a cycle with `valid_in` high.
- R5: While `valid_in` is low, `residue` and `short_err` keep their values.
- R6: With `short_op` high, `residue` equals bits [127:0] of the first pass, x_L ^ (x_H·0x87), where x_H = input[254:128]. When one operand is at most 122 bits wide, this equals the full residue.
- R7: With `short_op` high, `short_err` is set exactly when bits [133:128] of the first pass are nonzero.
- R8: A synchronous active-high reset clears `valid_out`, `residue` and `short_err` to zero.
- R9: With `short_op` low, `short_err` is zero for that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Product on `prod_in` is valid this cycle |
| short_op | input | 1 | Select the single-pass result |
| prod_in | input | 256 | Carryless product; bit 255 is ignored |
| valid_out | output | 1 | `residue` carries a new result |
| residue | output | 128 | Reduced 128-bit value |
| short_err | output | 1 | Single-pass result overflowed 128 bits |

## Verification
Every result is due on the first rising edge after the edge where `valid_in` is sampled high. At that edge `residue`, `short_err` and `valid_out` all change together. The bench drives each input on a falling edge and lowers `valid_in` on the next falling edge. It reads the outputs at that same falling edge, half a period after the registers have loaded. Hold checks change `prod_in` while `valid_in` is low, then read the outputs one full cycle later.

// File: rtl/gfr_pkg.sv
package gfr_pkg;
  localparam int RES_W_DEF  = 128;
  localparam int TAIL_W_DEF = 8;
  localparam logic [TAIL_W_DEF-1:0] TAIL_DEF = 8'h87;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gfr_tailmul.sv
module gfr_tailmul #(
  parameter int IN_W   = 127,
  parameter int TAIL_W = 8,
  parameter logic [TAIL_W-1:0] TAIL = 8'h87,
  localparam int OUT_W = IN_W + TAIL_W - 1
) (
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] y
);
  logic [OUT_W-1:0] term [TAIL_W];

  for (genvar k = 0; k < TAIL_W; k++) begin : g_tap
    if (TAIL[k]) begin : g_on
      assign term[k] = OUT_W'(x) << k;
    end else begin : g_off
      assign term[k] = '0;
    end
  end

  always_comb begin
    y = '0;
    for (int k = 0; k < TAIL_W; k++) y = y ^ term[k];
  end
endmodule

// File: rtl/gfr_fold.sv
module gfr_fold #(
  parameter int IN_W   = 255,
  parameter int RES_W  = 128,
  parameter int TAIL_W = 8,
  parameter logic [TAIL_W-1:0] TAIL = 8'h87,
  parameter int OUT_W  = 134
) (
  input  logic [IN_W-1:0]  v,
  output logic [OUT_W-1:0] f
);
  localparam int HI_W = IN_W - RES_W;
  localparam int P_W  = HI_W + TAIL_W - 1;

  logic [P_W-1:0] prod;

  gfr_tailmul #(.IN_W(HI_W), .TAIL_W(TAIL_W), .TAIL(TAIL)) u_mul (
    .x(v[IN_W-1:RES_W]),
    .y(prod)
  );

  assign f = OUT_W'(v[RES_W-1:0]) ^ OUT_W'(prod);
endmodule

// File: rtl/gf128_reduce.sv
module gf128_reduce
  import gfr_pkg::*;
#(
  parameter int RES_W  = RES_W_DEF,
  parameter int TAIL_W = TAIL_W_DEF,
  parameter logic [TAIL_W-1:0] TAIL = TAIL_DEF,
  localparam int PROD_W = 2 * RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic              short_op,
  input  logic [PROD_W-1:0] prod_in,
  output logic              valid_out,
  output logic [RES_W-1:0]  residue,
  output logic              short_err
);
  localparam int USE_W   = PROD_W - 1;
  localparam int FIRST_W = imax(RES_W, (USE_W - RES_W) + TAIL_W - 1);
  localparam int OVF_W   = FIRST_W - RES_W;

  logic msb_unused;
  assign msb_unused = prod_in[PROD_W-1];

  logic [FIRST_W-1:0] pass1;
  logic [RES_W-1:0]   pass2;
  logic [OVF_W-1:0]   ovf;

  gfr_fold #(.IN_W(USE_W), .RES_W(RES_W), .TAIL_W(TAIL_W), .TAIL(TAIL),
             .OUT_W(FIRST_W)) u_fold1 (
    .v(prod_in[USE_W-1:0]),
    .f(pass1)
  );

  gfr_fold #(.IN_W(FIRST_W), .RES_W(RES_W), .TAIL_W(TAIL_W), .TAIL(TAIL),
             .OUT_W(RES_W)) u_fold2 (
    .v(pass1),
    .f(pass2)
  );

  assign ovf = pass1[FIRST_W-1:RES_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      residue   <= '0;
      short_err <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        residue   <= short_op ? pass1[RES_W-1:0] : pass2;
        short_err <= short_op & (|ovf);
      end
    end
  end
endmodule

// File: rtl/gf128_reduce_chk.sv
module gf128_reduce_chk #(
  parameter int RES_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               valid_in,
  input logic               short_op,
  input logic [2*RES_W-2:0] prod,
  input logic               valid_out,
  input logic [RES_W-1:0]   residue,
  input logic               short_err
);
  p_valid_rise_r4: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  p_valid_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  p_hold_res_r5: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(residue) && $stable(short_err)));
  p_low_only_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && prod[2*RES_W-2:RES_W] == '0) |=> residue == $past(prod[RES_W-1:0]));
  p_full_noerr_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !short_op) |=> !short_err);
  p_err_src_r7: assert property (@(posedge clk) disable iff (rst)
    (short_err && valid_out) |-> $past(short_op));
endmodule

bind gf128_reduce gf128_reduce_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .short_op(short_op),
  .prod(prod_in[2*RES_W-2:0]), .valid_out(valid_out),
  .residue(residue), .short_err(short_err)
);

// File: tb/sim_gf128_reduce.sv
`timescale 1ns/1ps
module sim_gf128_reduce;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic         short_op = 1'b0;
  logic [255:0] prod_in = '0;
  logic         valid_out;
  logic [127:0] residue;
  logic         short_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gf128_reduce u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .short_op(short_op),
    .prod_in(prod_in), .valid_out(valid_out), .residue(residue),
    .short_err(short_err)
  );

  function automatic logic [255:0] clmul(input logic [127:0] a, input logic [127:0] b);
    logic [255:0] r = '0;
    for (int i = 0; i < 128; i++) if (b[i]) r = r ^ ({128'd0, a} << i);
    return r;
  endfunction

  function automatic logic [127:0] ref_mod(input logic [255:0] p);
    logic [255:0] r = {1'b0, p[254:0]};
    logic [255:0] m = {127'd0, 1'b1, 120'd0, 8'h87};
    for (int i = 254; i >= 128; i--) if (r[i]) r = r ^ (m << (i - 128));
    return r[127:0];
  endfunction

  function automatic logic [133:0] ref_pass1(input logic [255:0] p);
    logic [133:0] h = {7'd0, p[254:128]};
    return {6'd0, p[127:0]} ^ h ^ (h << 1) ^ (h << 2) ^ (h << 7);
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk128(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input logic [255:0] p, input logic s);
    @(negedge clk);
    prod_in  = p;
    short_op = s;
    valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic full_case(input string tag, input logic [255:0] p);
    run(p, 1'b0);
    chk1({tag, " R4 valid"}, valid_out, 1'b1);
    chk128({tag, " R1 residue"}, residue, ref_mod(p));
    chk1({tag, " R9 err"}, short_err, 1'b0);
  endtask

  task automatic short_case(input string tag, input logic [255:0] p);
    logic [133:0] f = ref_pass1(p);
    run(p, 1'b1);
    chk128({tag, " R6 residue"}, residue, f[127:0]);
    chk1({tag, " R7 err"}, short_err, |f[133:128]);
  endtask

  function automatic string pos_tag(input string base, input int idx);
    return $sformatf("%s %0d", base, idx);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] p, q;
    logic [127:0] a, b;
    logic [127:0] held;
    logic held_err;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk1("R8 valid_out", valid_out, 1'b0);
    chk128("R8 residue", residue, '0);
    chk1("R8 short_err", short_err, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk1("R4 idle", valid_out, 1'b0);

    // directed single bits: 127, 128, 254
    full_case("bit127", 256'd1 << 127);
    full_case("bit128", 256'd1 << 128);
    full_case("bit254", 256'd1 << 254);
    short_case("bit254s", 256'd1 << 254);
    // R3 low-only passthrough in both modes
    p = {128'd0, rnd256() >> 128};
    full_case("R3 full", p);
    chk128("R3 full pass", residue, p[127:0]);
    run(p, 1'b1);
    chk128("R3 short pass", residue, p[127:0]);
    chk1("R3 short err", short_err, 1'b0);
    // all-ones operands
    full_case("ones", clmul('1, '1));
    short_case("ones short", clmul('1, '1));
    // R2 bit 255 ignored
    run(256'd1 << 255, 1'b0);
    chk128("R2 msb only", residue, '0);
    p = rnd256();
    p[255] = 1'b0;
    run(p, 1'b1);
    a = residue; held_err = short_err;
    p[255] = 1'b1;
    run(p, 1'b1);
    chk128("R2 residue", residue, a);
    chk1("R2 err", short_err, held_err);

    // R5 hold while idle
    held = residue; held_err = short_err;
    @(negedge clk);
    prod_in = ~prod_in;
    short_op = 1'b0;
    @(negedge clk);
    chk1("R4 low", valid_out, 1'b0);
    chk128("R5 residue hold", residue, held);
    chk1("R5 err hold", short_err, held_err);

    // random full products
    for (int i = 0; i < 40; i++) begin
      a = rnd256()[127:0]; b = rnd256()[127:0];
      full_case(pos_tag("rnd", i), clmul(a, b));
    end
    // random raw words in both modes
    for (int i = 0; i < 20; i++) begin
      q = rnd256();
      full_case(pos_tag("raw", i), q);
      short_case(pos_tag("raws", i), q);
    end
    // R6 short operand: single pass equals full residue, no error
    for (int i = 0; i < 20; i++) begin
      a = rnd256()[127:0] >> 6; b = rnd256()[127:0];
      p = clmul(a, b);
      run(p, 1'b1);
      chk128(pos_tag("R6 short residue", i), residue, ref_mod(p));
      chk1(pos_tag("R7 short noerr", i), short_err, 1'b0);
    end
    // R7 forced overflow: top bit set gives overflow
    p = 256'd1 << 254;
    run(p, 1'b1);
    chk1("R7 overflow", short_err, 1'b1);
    full_case("R9 after", p);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule